// File: doc/BRIEF.md
# Stall-on-Use Selective Scoreboard

This block sits beside the issue stage of a wide in-order core and remembers which architectural registers are still waiting on a result whose latency cannot be known when the code is scheduled. Only loads and variable-latency floating-point operations mark their destinations as pending. Ordinary ALU results are left to the compiler's static scheduling and are never tracked. A completing unit clears a bit. A pipeline cancel removes every pending bit whose producer carried the cancelled packet tag.

The check side compares every source operand of the candidate packet against a mirrored copy of the pending vector. That copy stands for a scoreboard replica placed far away, so it lags the master copy by one cycle. A packet that reads a pending result is held. A packet with no such consumer keeps flowing, even while a miss is outstanding. Because of the lag, the packet issued directly after a producer is never checked against it. Software must not place a consumer there. The hold output is registered. When the load decoupling queue is full, a candidate that contains a load is either held or flagged for recirculation, and a parameter selects which.

Top module: `sou_scoreboard`

## Requirements
- R1: Only operations of class 1 (load) or class 2 (variable-latency floating point) in a valid issuing packet mark their destination pending. Class 0 (ALU) and class 3 never change any pending bit.
- R2: `hold` is 1 in the cycle after a check only if some valid source slot named a register whose mirrored bit was set, or if the R7 hold case applied. With no such consumer, `hold` stays 0 even while results are pending.
- R3: The mirrored copy equals the master copy one cycle earlier. A register set at issue edge k is seen by checks sampled at edge k+2 but not at edge k+1. `hold` appears just after the edge that sampled the check.
- R4: A completion clear at edge k stops a hazard for checks from edge k+2 on. A check at edge k+1 still sees the register as pending.
- R5: If an issue set and a completion clear or flush hit the same register in one cycle, the register ends up pending.
- R6: A flush clears exactly those pending registers whose recorded tag equals `flush_tag`. A register records `iss_tag` each time it is set. Other registers are unaffected.
- R7: When `chk_has_load` and `lsq_full` are both 1, `hold` follows in the next cycle if FULL_REJECT is 0. If FULL_REJECT is 1, `reject` follows and this case adds nothing to `hold`. Otherwise `reject` is 0.
- R8: While `rst_n` is low, all pending bits are cleared and `hold` and `reject` are 0.
- R9: Any of the OPS*SRCS source slots can raise a hazard. Slot s is source s%SRCS of operation s/SRCS, and its register number is in `chk_src[s*RW +: RW]`. Operation o of the set port uses `iss_cls[2*o +: 2]` and `iss_dst[o*RW +: RW]`. One packet may set several registers at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld | input | 1 | A packet issues this cycle |
| iss_cls | input | 2*OPS | Operation class per slot (0 ALU, 1 load, 2 variable FP, 3 other) |
| iss_dst | input | RW*OPS | Destination register per slot |
| iss_tag | input | TAGW | Packet tag of the issuing packet |
| cmp_vld | input | CLRS | Completion clear valid per return lane |
| cmp_reg | input | RW*CLRS | Register cleared per return lane |
| flush_vld | input | 1 | Cancel request |
| flush_tag | input | TAGW | Tag of the cancelled packet |
| chk_src_vld | input | OPS*SRCS | Source slot valid in the candidate packet |
| chk_src | input | RW*OPS*SRCS | Source register per slot |
| chk_has_load | input | 1 | Candidate packet contains a load |
| lsq_full | input | 1 | Load decoupling queue has no free entry |
| hold | output | 1 | Registered: keep the candidate at issue |
| reject | output | 1 | Registered: send the candidate back for recirculation |

## Verification
The properties assume that the set, clear and flush ports carry register numbers below NREG, and that reset is held for several cycles before any traffic. This keeps the one-cycle look-back of the mirror property well defined. The bench drives only in-range numbers from four-bit fields of a 16-register configuration. It lets reset run for four edges before the first packet. It also builds deliberate overlaps, such as set with clear, set with flush, and reads in the dead cycle right after a producer, so the priority and lag properties are exercised rather than left vacuous.

// File: rtl/sou_pkg.sv
// Shared definitions for the stall-on-use scoreboard.
// Assumes operation class is a 2-bit code supplied by decode.
package sou_pkg;

    typedef enum logic [1:0] {
        OPC_ALU   = 2'd0,
        OPC_LOAD  = 2'd1,
        OPC_FPVAR = 2'd2,
        OPC_OTHER = 2'd3
    } op_cls_e;

    // True for classes whose result latency is not known at schedule time.
    function automatic logic cls_tracked(input logic [1:0] cls);
        return (cls == OPC_LOAD) || (cls == OPC_FPVAR);
    endfunction

endpackage

// File: rtl/sou_sb_state.sv
// Master pending vector with one producer tag per register.
// Sets come from issue (tracked classes only), clears from completion lanes
// and from tag-matched flushes; a set in the same cycle wins.
// Assumes NREG is a power of two so every RW-bit number is in range.
module sou_sb_state #(
    parameter int NREG = 16,
    parameter int OPS  = 6,
    parameter int CLRS = 2,
    parameter int TAGW = 4,
    parameter int RW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_vld,
    input  logic [2*OPS-1:0]     iss_cls,
    input  logic [RW*OPS-1:0]    iss_dst,
    input  logic [TAGW-1:0]      iss_tag,
    input  logic [CLRS-1:0]      cmp_vld,
    input  logic [RW*CLRS-1:0]   cmp_reg,
    input  logic                 flush_vld,
    input  logic [TAGW-1:0]      flush_tag,
    output logic [NREG-1:0]      pend_o,
    output logic [NREG*TAGW-1:0] tag_o
);
    import sou_pkg::*;

    logic [NREG-1:0] pend_q;
    logic [NREG-1:0] set_hit;
    logic [NREG-1:0] kill_hit;
    logic [TAGW-1:0] tag_q [NREG];

    // Decode which registers the issuing packet marks pending.
    always_comb begin
        set_hit = '0;
        for (int o = 0; o < OPS; o++) begin
            if (iss_vld && cls_tracked(iss_cls[2*o +: 2])) begin
                set_hit[iss_dst[o*RW +: RW]] = 1'b1;
            end
        end
    end

    // Decode which registers are released by completion or flush.
    always_comb begin
        kill_hit = '0;
        for (int c = 0; c < CLRS; c++) begin
            if (cmp_vld[c]) begin
                kill_hit[cmp_reg[c*RW +: RW]] = 1'b1;
            end
        end
        for (int r = 0; r < NREG; r++) begin
            if (flush_vld && pend_q[r] && (tag_q[r] == flush_tag)) begin
                kill_hit[r] = 1'b1;
            end
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_entry
        // Update one pending bit and its tag; set has priority over release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[r] <= 1'b0;
                tag_q[r]  <= '0;
            end else if (set_hit[r]) begin
                pend_q[r] <= 1'b1;
                tag_q[r]  <= iss_tag;
            end else if (kill_hit[r]) begin
                pend_q[r] <= 1'b0;
            end
        end
        assign tag_o[r*TAGW +: TAGW] = tag_q[r];
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/sou_sb_mirror.sv
// Remote copy of the pending vector, one register stage behind the master.
// Models the wire delay to a distant issue-side replica.
module sou_sb_mirror #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] loc_i,
    output logic [W-1:0] rem_o
);
    // Copy the master vector one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) rem_o <= '0;
        else        rem_o <= loc_i;
    end
endmodule

// File: rtl/sou_sb_hazard.sv
// Combinational hazard test: any valid source slot naming a pending register.
// Assumes the source numbers index a vector of NREG entries.
module sou_sb_hazard #(
    parameter int NREG  = 16,
    parameter int SLOTS = 18,
    parameter int RW    = 4
) (
    input  logic [NREG-1:0]     rem_i,
    input  logic [SLOTS-1:0]    src_vld_i,
    input  logic [RW*SLOTS-1:0] src_i,
    output logic                hit_o
);
    // OR together the per-slot lookups in the mirrored vector.
    always_comb begin
        hit_o = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (src_vld_i[s] && rem_i[src_i[s*RW +: RW]]) begin
                hit_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sou_scoreboard.sv
// Stall-on-use scoreboard top. Tracks only unpredictable-latency results,
// checks the candidate packet against a one-cycle-late replica and
// registers the hold and reject decisions.
// Assumes the issue stage never places a consumer in the packet right after
// its producer (that slot is not checked).
module sou_scoreboard #(
    parameter int NREG        = 16,
    parameter int OPS         = 6,
    parameter int SRCS        = 3,
    parameter int CLRS        = 2,
    parameter int TAGW        = 4,
    parameter bit FULL_REJECT = 1'b0,
    localparam int RW         = $clog2(NREG),
    localparam int SLOTS      = OPS * SRCS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iss_vld,
    input  logic [2*OPS-1:0]    iss_cls,
    input  logic [RW*OPS-1:0]   iss_dst,
    input  logic [TAGW-1:0]     iss_tag,
    input  logic [CLRS-1:0]     cmp_vld,
    input  logic [RW*CLRS-1:0]  cmp_reg,
    input  logic                flush_vld,
    input  logic [TAGW-1:0]     flush_tag,
    input  logic [SLOTS-1:0]    chk_src_vld,
    input  logic [RW*SLOTS-1:0] chk_src,
    input  logic                chk_has_load,
    input  logic                lsq_full,
    output logic                hold,
    output logic                reject
);
    logic [NREG-1:0]      pend_loc;
    logic [NREG-1:0]      pend_rem;
    logic [NREG*TAGW-1:0] tag_flat;
    logic                 hz_hit;
    logic                 load_blocked;

    sou_sb_state #(
        .NREG(NREG), .OPS(OPS), .CLRS(CLRS), .TAGW(TAGW), .RW(RW)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_vld   (iss_vld),
        .iss_cls   (iss_cls),
        .iss_dst   (iss_dst),
        .iss_tag   (iss_tag),
        .cmp_vld   (cmp_vld),
        .cmp_reg   (cmp_reg),
        .flush_vld (flush_vld),
        .flush_tag (flush_tag),
        .pend_o    (pend_loc),
        .tag_o     (tag_flat)
    );

    sou_sb_mirror #(.W(NREG)) u_mirror (
        .clk   (clk),
        .rst_n (rst_n),
        .loc_i (pend_loc),
        .rem_o (pend_rem)
    );

    sou_sb_hazard #(.NREG(NREG), .SLOTS(SLOTS), .RW(RW)) u_hazard (
        .rem_i     (pend_rem),
        .src_vld_i (chk_src_vld),
        .src_i     (chk_src),
        .hit_o     (hz_hit)
    );

    assign load_blocked = chk_has_load && lsq_full;

    // Register the issue-side decisions; the full-queue policy is fixed here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= 1'b0;
            reject <= 1'b0;
        end else begin
            hold   <= hz_hit || (!FULL_REJECT && load_blocked);
            reject <= FULL_REJECT && load_blocked;
        end
    end

endmodule

// File: rtl/sou_scoreboard_chk.sv
// Property checker for sou_scoreboard, attached by bind below.
// Assumes register numbers on all ports are below NREG.
module sou_scoreboard_chk #(
    parameter int NREG  = 16,
    parameter int OPS   = 6,
    parameter int CLRS  = 2,
    parameter int TAGW  = 4,
    parameter int RW    = 4,
    parameter int SLOTS = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_vld,
    input logic [2*OPS-1:0]     iss_cls,
    input logic [RW*OPS-1:0]    iss_dst,
    input logic [TAGW-1:0]      iss_tag,
    input logic [CLRS-1:0]      cmp_vld,
    input logic [RW*CLRS-1:0]   cmp_reg,
    input logic                 flush_vld,
    input logic [TAGW-1:0]      flush_tag,
    input logic [SLOTS-1:0]     chk_src_vld,
    input logic                 chk_has_load,
    input logic                 lsq_full,
    input logic                 hold,
    input logic                 reject,
    input logic [NREG-1:0]      pend_loc,
    input logic [NREG-1:0]      pend_rem,
    input logic [NREG*TAGW-1:0] tag_flat
);
    logic [NREG-1:0] c_set;
    logic [NREG-1:0] c_clr;

    // Checker-side view of which registers the port traffic targets.
    always_comb begin
        c_set = '0;
        c_clr = '0;
        for (int o = 0; o < OPS; o++) begin
            if (iss_vld && (iss_cls[2*o +: 2] == 2'd1 || iss_cls[2*o +: 2] == 2'd2))
                c_set[iss_dst[o*RW +: RW]] = 1'b1;
        end
        for (int c = 0; c < CLRS; c++) begin
            if (cmp_vld[c]) c_clr[cmp_reg[c*RW +: RW]] = 1'b1;
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        p_tracked_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_loc[r]) |-> $past(c_set[r]));
        p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (c_clr[r] && !c_set[r]) |=> !pend_loc[r]);
        p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            c_set[r] |=> pend_loc[r]);
        p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_vld && tag_flat[r*TAGW +: TAGW] == flush_tag && !c_set[r]) |=> !pend_loc[r]);
        p_tag_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
            c_set[r] |=> (tag_flat[r*TAGW +: TAGW] == $past(iss_tag)));
    end

    p_mirror_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_rem == $past(pend_loc));
    p_hold_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> $past((|chk_src_vld) || (chk_has_load && lsq_full)));
    p_reject_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(chk_has_load && lsq_full));
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> (!hold && !reject && pend_loc == '0));

endmodule

bind sou_scoreboard sou_scoreboard_chk #(
    .NREG(NREG), .OPS(OPS), .CLRS(CLRS), .TAGW(TAGW), .RW(RW), .SLOTS(SLOTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_vld      (iss_vld),
    .iss_cls      (iss_cls),
    .iss_dst      (iss_dst),
    .iss_tag      (iss_tag),
    .cmp_vld      (cmp_vld),
    .cmp_reg      (cmp_reg),
    .flush_vld    (flush_vld),
    .flush_tag    (flush_tag),
    .chk_src_vld  (chk_src_vld),
    .chk_has_load (chk_has_load),
    .lsq_full     (lsq_full),
    .hold         (hold),
    .reject       (reject),
    .pend_loc     (pend_loc),
    .pend_rem     (pend_rem),
    .tag_flat     (tag_flat)
);

// File: tb/sou_scoreboard_tb_top.sv
// Bench: two instances (hold policy and reject policy) driven together,
// compared every cycle against an arithmetic model plus directed checks.
module sou_scoreboard_tb_top;
    localparam int NR = 16;
    localparam int NO = 6;
    localparam int NS = 3;
    localparam int NC = 2;
    localparam int TW = 4;
    localparam int RB = 4;
    localparam int SL = NO * NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_vld;
    logic [2*NO-1:0] iss_cls;
    logic [RB*NO-1:0] iss_dst;
    logic [TW-1:0] iss_tag;
    logic [NC-1:0] cmp_vld;
    logic [RB*NC-1:0] cmp_reg;
    logic flush_vld;
    logic [TW-1:0] flush_tag;
    logic [SL-1:0] chk_src_vld;
    logic [RB*SL-1:0] chk_src;
    logic chk_has_load, lsq_full;
    logic hold_a, rej_a, hold_b, rej_b;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    string cur_req = "R8";

    bit m_loc [NR];
    bit m_rem [NR];
    logic [TW-1:0] m_tag [NR];

    always #2 clk = ~clk;

    sou_scoreboard #(.NREG(NR), .OPS(NO), .SRCS(NS), .CLRS(NC), .TAGW(TW), .FULL_REJECT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cls(iss_cls), .iss_dst(iss_dst),
        .iss_tag(iss_tag), .cmp_vld(cmp_vld), .cmp_reg(cmp_reg), .flush_vld(flush_vld),
        .flush_tag(flush_tag), .chk_src_vld(chk_src_vld), .chk_src(chk_src),
        .chk_has_load(chk_has_load), .lsq_full(lsq_full), .hold(hold_a), .reject(rej_a));

    sou_scoreboard #(.NREG(NR), .OPS(NO), .SRCS(NS), .CLRS(NC), .TAGW(TW), .FULL_REJECT(1'b1)) dut_rej_i (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cls(iss_cls), .iss_dst(iss_dst),
        .iss_tag(iss_tag), .cmp_vld(cmp_vld), .cmp_reg(cmp_reg), .flush_vld(flush_vld),
        .flush_tag(flush_tag), .chk_src_vld(chk_src_vld), .chk_src(chk_src),
        .chk_has_load(chk_has_load), .lsq_full(lsq_full), .hold(hold_b), .reject(rej_b));

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        iss_vld = 0; iss_cls = '0; iss_dst = '0; iss_tag = '0;
        cmp_vld = '0; cmp_reg = '0; flush_vld = 0; flush_tag = '0;
        chk_src_vld = '0; chk_src = '0; chk_has_load = 0; lsq_full = 0;
    endtask

    task automatic set_op(input int o, input logic [1:0] c, input int d);
        iss_cls[2*o +: 2] = c;
        iss_dst[o*RB +: RB] = d[RB-1:0];
    endtask

    task automatic rd(input int s, input int r);
        chk_src_vld[s] = 1'b1;
        chk_src[s*RB +: RB] = r[RB-1:0];
    endtask

    // One clock: model the edge from the driven inputs, then compare outputs.
    task automatic step();
        bit hz, lb;
        bit nset [NR];
        bit nkill [NR];
        @(posedge clk);
        hz = 0;
        for (int s = 0; s < SL; s++)
            if (chk_src_vld[s] && m_rem[chk_src[s*RB +: RB]]) hz = 1;
        lb = chk_has_load && lsq_full;
        for (int r = 0; r < NR; r++) begin nset[r] = 0; nkill[r] = 0; end
        for (int o = 0; o < NO; o++)
            if (iss_vld && (iss_cls[2*o +: 2] == 2'd1 || iss_cls[2*o +: 2] == 2'd2))
                nset[iss_dst[o*RB +: RB]] = 1;
        for (int c = 0; c < NC; c++)
            if (cmp_vld[c]) nkill[cmp_reg[c*RB +: RB]] = 1;
        for (int r = 0; r < NR; r++)
            if (flush_vld && m_loc[r] && m_tag[r] == flush_tag) nkill[r] = 1;
        for (int r = 0; r < NR; r++) begin
            m_rem[r] = m_loc[r];
            if (nset[r]) begin m_loc[r] = 1; m_tag[r] = iss_tag; end
            else if (nkill[r]) m_loc[r] = 0;
        end
        #1;
        check(cur_req, "hold (hold policy)", hold_a, hz | lb);
        check(cur_req, "reject (hold policy)", rej_a, 1'b0);
        check(cur_req, "hold (reject policy)", hold_b, hz);
        check(cur_req, "reject (reject policy)", rej_b, lb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle();
        for (int r = 0; r < NR; r++) begin m_loc[r] = 0; m_rem[r] = 0; m_tag[r] = '0; end
        // R8: reset with traffic on the inputs must leave everything clear
        iss_vld = 1; set_op(0, 2'd1, 3); chk_has_load = 1; lsq_full = 1;
        repeat (4) @(posedge clk);
        #1;
        check("R8", "hold in reset", hold_a, 1'b0);
        check("R8", "reject in reset", rej_b, 1'b0);
        idle();
        rst_n = 1;
        cur_req = "R8";
        step();

        // R1/R3/R4 sweep: every register, every class
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < 4; c++) begin
                bit trk;
                trk = (c == 1) || (c == 2);
                cur_req = "R1";
                idle(); iss_vld = 1; set_op(c % NO, c[1:0], r); iss_tag = r[TW-1:0]; step();
                idle(); rd((r + c) % SL, r); step();
                check("R3", "dead-cycle consumer not held", hold_a, 1'b0);
                idle(); rd((r + c + 5) % SL, r); step();
                check("R1", "consumer held only for tracked class", hold_a, trk);
                cur_req = "R4";
                idle(); cmp_vld[c % NC] = 1; cmp_reg[(c % NC)*RB +: RB] = r[RB-1:0]; step();
                idle(); rd(r % SL, r); step();
                check("R4", "replica still pending one cycle after clear", hold_a, trk);
                idle(); rd(r % SL, r); step();
                check("R4", "cleared register not held", hold_a, 1'b0);
            end
        end

        // R2: pending load with no consumer keeps flowing
        cur_req = "R2";
        idle(); iss_vld = 1; set_op(0, 2'd1, 7); step();
        idle(); step(); idle(); rd(0, 6); rd(17, 8); step();
        check("R2", "non-consumer not held", hold_a, 1'b0);
        idle(); cmp_vld[0] = 1; cmp_reg[0 +: RB] = 4'd7; step(); idle(); step();

        // R5: set and clear collide on one register
        cur_req = "R5";
        idle(); iss_vld = 1; set_op(3, 2'd2, 5); cmp_vld = 2'b11;
        cmp_reg = {4'd5, 4'd5}; step();
        idle(); step(); idle(); rd(4, 5); step();
        check("R5", "set beats clear", hold_a, 1'b1);
        idle(); iss_vld = 1; set_op(0, 2'd1, 5); iss_tag = 4'd3;
        flush_vld = 1; flush_tag = 4'd3; step();
        idle(); step(); idle(); rd(2, 5); step();
        check("R5", "set beats flush", hold_a, 1'b1);
        idle(); cmp_vld[1] = 1; cmp_reg[RB +: RB] = 4'd5; step(); idle(); step();

        // R6/R9: two tagged packets, each setting six registers
        cur_req = "R6";
        idle(); iss_vld = 1; iss_tag = 4'd5;
        for (int o = 0; o < NO; o++) set_op(o, 2'd1, o);
        step();
        idle(); iss_vld = 1; iss_tag = 4'd6;
        for (int o = 0; o < NO; o++) set_op(o, 2'd2, 8 + o);
        step();
        idle(); flush_vld = 1; flush_tag = 4'd5; step();
        idle(); step();
        idle(); rd(0, 0); step();
        check("R6", "flushed tag released", hold_a, 1'b0);
        idle(); rd(1, 8); step();
        check("R6", "other tag kept", hold_a, 1'b1);
        idle(); flush_vld = 1; flush_tag = 4'd9; step(); idle(); step();
        idle(); rd(2, 9); step();
        check("R6", "unmatched flush no effect", hold_a, 1'b1);
        cur_req = "R9";
        for (int s = 0; s < SL; s++) begin
            idle(); rd(s, 8 + (s % NO)); step();
            check("R9", "slot sees pending register", hold_a, 1'b1);
            idle(); rd(s, 15); step();
            check("R9", "slot idle register", hold_a, 1'b0);
        end
        cur_req = "R6";
        idle(); flush_vld = 1; flush_tag = 4'd6; step(); idle(); step();
        idle(); rd(3, 10); step();
        check("R6", "second flush released", hold_a, 1'b0);

        // R7: full load queue policy
        cur_req = "R7";
        idle(); chk_has_load = 1; lsq_full = 1; step();
        check("R7", "hold policy holds", hold_a, 1'b1);
        check("R7", "reject policy rejects", rej_b, 1'b1);
        check("R7", "reject policy no hold", hold_b, 1'b0);
        idle(); chk_has_load = 1; step();
        check("R7", "load with room", rej_b, 1'b0);
        idle(); lsq_full = 1; step();
        check("R7", "full without load", hold_a, 1'b0);

        // R2: mixed traffic against the model
        cur_req = "R2";
        for (int k = 0; k < 4000; k++) begin
            idle();
            iss_vld = ($urandom % 3) == 0;
            iss_tag = TW'($urandom);
            for (int o = 0; o < NO; o++) set_op(o, 2'($urandom), int'($urandom % NR));
            cmp_vld = NC'($urandom);
            cmp_reg = (RB*NC)'($urandom);
            flush_vld = ($urandom % 8) == 0;
            flush_tag = TW'($urandom);
            for (int s = 0; s < SL; s++)
                if (($urandom % 6) == 0) rd(s, int'($urandom % NR));
            chk_has_load = ($urandom % 4) == 0;
            lsq_full = ($urandom % 4) == 0;
            step();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule